// File: doc/BRIEF.md
# Autoincrement Write Burst Queue

This block sits between a host cycle decoder and an internal memory write port. The host sets a write pointer with an address write. It then streams data words with autoincrement writes. Each word is queued together with the word address it is destined for, and the pointer then advances by one. The memory side sees a simple request/acknowledge port carrying an address and a data word. Queued words are released as a burst once enough of them have gathered, or sooner when the host needs the queue emptied.

Two kinds of host access force the queue to empty before they proceed: an address write, and any access that does not use autoincrement. While such an access waits, the ready output stays low and the queue drains regardless of its fill level. Autoincrement writes are accepted back to back with ready high for as long as a slot is free. While reset is held, the queue is empty and ready stays low.

Top module: `autoinc_wr_fifo`

## Requirements
- R1: While rstN is low, hostReady and memReq are low. After reset is released with no access pending, hostReady is high and memReq is low.
- R2: An accepted access with hostKind = 2'b10 (address write) loads hostData as the write pointer. The next autoincrement word is stored with that address.
- R3: An accepted access with hostKind = 2'b01 (autoincrement write) queues hostData with the current write pointer, and only then adds one to the pointer.
- R4: Queued words leave on the memory port in arrival order, each with the address and data it was queued with.
- R5: With fewer than THRESH words queued, no burst in progress and no flushing access waiting, memReq stays low.
- R6: Once THRESH or more words are queued, memReq rises, and the burst continues until the queue is empty.
- R7: An autoincrement write is accepted (hostReady high) whenever the queue holds fewer than DEPTH words. There are no wait states while room remains.
- R8: With DEPTH words queued, hostReady is low. It returns high in the cycle after one entry has drained.
- R9: An address write or a non-autoincrement access (hostKind 2'b00 or 2'b11), presented while the queue is not empty, sees hostReady low and forces memReq high. It is accepted only once the queue is empty.
- R10: An accepted access with hostKind 2'b00 or 2'b11 changes neither the write pointer nor the queue.
- R11: While memReq is high and memAck is low, memReq stays high and memAddr and memData hold their values.
- R12: Asserting rstN low mid-operation discards all queued words and returns the write pointer to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; holds the queue cleared |
| hostValid | input | 1 | Host access presented this cycle |
| hostKind | input | 2 | Access type: 01 autoincrement write, 10 address write, 00/11 other access |
| hostData | input | DATA_W | Data word, or the new pointer for an address write |
| hostReady | output | 1 | High when the presented access is accepted this cycle |
| memReq | output | 1 | Memory write request |
| memAck | input | 1 | Memory accepts the current request |
| memAddr | output | ADDR_W | Word address of the head entry |
| memData | output | DATA_W | Data of the head entry |

## Verification
The bench builds the block with its default parameters: a depth of 8, a burst threshold of 4, and 32-bit addresses and data. With these values, a full queue is reached after a handful of writes with acknowledge held low. Pointer wrap in the storage happens many times within a few thousand random cycles. The gap between the threshold and full leaves room to hit the R5 quiet window, the R6 burst start and the R8 full stall in short directed runs. Random acknowledge gaps drive the R11 hold case.

// File: rtl/aiwf_pkg.sv
package aiwf_pkg;

  typedef enum logic [1:0] {
    KIND_OTHER_LO = 2'b00,
    KIND_AUTO     = 2'b01,
    KIND_ADDR     = 2'b10,
    KIND_OTHER_HI = 2'b11
  } hostKind_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic loadAddr;
  } ctrlStrb_t;

endpackage

// File: rtl/aiwf_ctrl.sv
module aiwf_ctrl
  import aiwf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int THRESH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostValid,
  input  logic [1:0]       hostKind,
  input  logic             memAck,
  output logic             hostReady,
  output logic             memReq,
  output ctrlStrb_t        strb,
  output logic [CNT_W-1:0] fillLevel
);

  logic [CNT_W-1:0] count, countNext;
  logic burstActive, burstNext;
  logic isEmpty, isFull, isFlushKind, flushNeed, accept;

  assign isEmpty     = (count == '0);
  assign isFull      = (count == CNT_W'(DEPTH));
  assign isFlushKind = (hostKind != KIND_AUTO);
  assign flushNeed   = hostValid && isFlushKind && !isEmpty;

  // Flush-type accesses wait for an empty queue; autoincrement waits only on full.
  assign hostReady = rstN && !isFull && !flushNeed;
  assign accept    = hostValid && hostReady;

  assign memReq = !isEmpty &&
                  (burstActive || (count >= CNT_W'(THRESH)) || flushNeed);

  always_comb begin
    strb          = '0;
    strb.push     = accept && (hostKind == KIND_AUTO);
    strb.loadAddr = accept && (hostKind == KIND_ADDR);
    strb.pop      = memReq && memAck;
    countNext     = count + CNT_W'(strb.push) - CNT_W'(strb.pop);
    burstNext     = memReq && (countNext != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count       <= '0;
      burstActive <= 1'b0;
    end else begin
      count       <= countNext;
      burstActive <= burstNext;
    end
  end

  assign fillLevel = count;

endmodule

// File: rtl/aiwf_dpath.sv
module aiwf_dpath
  import aiwf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] hostData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] nextAddr
);

  logic [ADDR_W-1:0] addrMem [DEPTH];
  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr, wrPtrInc, rdPtrInc;
  logic [ADDR_W-1:0] wrAddr;

  // Pointer advance: natural wrap for a power-of-two depth, explicit compare otherwise.
  generate
    if ((1 << PTR_W) == DEPTH) begin : g_pow2
      assign wrPtrInc = wrPtr + 1'b1;
      assign rdPtrInc = rdPtr + 1'b1;
    end else begin : g_mod
      assign wrPtrInc = (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      assign rdPtrInc = (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      wrAddr <= '0;
    end else begin
      if (strb.push) begin
        wrPtr  <= wrPtrInc;
        wrAddr <= wrAddr + 1'b1;
      end else if (strb.loadAddr) begin
        wrAddr <= hostData[ADDR_W-1:0];
      end
      if (strb.pop) rdPtr <= rdPtrInc;
    end
  end

  // Storage: each entry keeps the address it was queued with.
  always_ff @(posedge clk) begin
    if (strb.push) begin
      addrMem[wrPtr] <= wrAddr;
      dataMem[wrPtr] <= hostData;
    end
  end

  assign memAddr  = addrMem[rdPtr];
  assign memData  = dataMem[rdPtr];
  assign nextAddr = wrAddr;

endmodule

// File: rtl/autoinc_wr_fifo.sv
module autoinc_wr_fifo
  import aiwf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int THRESH = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  input  logic [1:0]        hostKind,
  input  logic [DATA_W-1:0] hostData,
  output logic              hostReady,
  output logic              memReq,
  input  logic              memAck,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  ctrlStrb_t         strb;
  logic [CNT_W-1:0]  fillLevel;
  logic [ADDR_W-1:0] nextAddr;

  aiwf_ctrl #(.DEPTH(DEPTH), .THRESH(THRESH)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostKind(hostKind),
    .memAck(memAck), .hostReady(hostReady), .memReq(memReq),
    .strb(strb), .fillLevel(fillLevel)
  );

  aiwf_dpath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .hostData(hostData),
    .memAddr(memAddr), .memData(memData), .nextAddr(nextAddr)
  );

endmodule

// File: rtl/aiwf_checks.sv
module aiwf_checks
  import aiwf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int THRESH = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostValid,
  input logic [1:0]        hostKind,
  input logic [DATA_W-1:0] hostData,
  input logic              hostReady,
  input logic              memReq,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memData,
  input ctrlStrb_t         strb,
  input logic [CNT_W-1:0]  fillLevel,
  input logic [ADDR_W-1:0] nextAddr
);

  p_ready_in_reset_r1: assert property (@(posedge clk)
    !rstN |-> (!hostReady && !memReq));

  p_addr_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadAddr |=> (nextAddr == $past(hostData[ADDR_W-1:0])));

  p_post_inc_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> (nextAddr == $past(nextAddr) + 1'b1));

  p_req_nonempty_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (fillLevel != '0));

  p_burst_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel >= CNT_W'(THRESH)) |-> memReq);

  p_room_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && hostKind == KIND_AUTO && fillLevel < CNT_W'(DEPTH)) |-> hostReady);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel == CNT_W'(DEPTH)) |-> (!hostReady && !strb.push));

  p_flush_wait_r9: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && hostKind != KIND_AUTO && fillLevel != '0) |-> (!hostReady && memReq));

  p_other_keeps_r10: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && hostReady && hostKind != KIND_AUTO && hostKind != KIND_ADDR)
      |=> $stable(nextAddr));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memData)));

endmodule

bind autoinc_wr_fifo aiwf_checks #(
  .DEPTH(DEPTH), .THRESH(THRESH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_checks (
  .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostKind(hostKind),
  .hostData(hostData), .hostReady(hostReady), .memReq(memReq), .memAck(memAck),
  .memAddr(memAddr), .memData(memData), .strb(strb), .fillLevel(fillLevel),
  .nextAddr(nextAddr)
);

// File: tb/autoinc_wr_fifo_test.sv
`timescale 1ns/1ps
module autoinc_wr_fifo_test;

  localparam int DEPTH  = 8;
  localparam int THRESH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostValid = 1'b0;
  logic [1:0]  hostKind = 2'b00;
  logic [31:0] hostData = '0;
  logic        hostReady, memReq;
  logic        memAck = 1'b0;
  logic [31:0] memAddr, memData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state
  logic [31:0] qA[$];
  logic [31:0] qD[$];
  logic [31:0] mAddr = '0;
  bit          mBurst = 0;
  bit          prevHold = 0;
  logic [31:0] prevA, prevD;

  always #4 clk = ~clk;

  autoinc_wr_fifo #(.DEPTH(DEPTH), .THRESH(THRESH), .ADDR_W(32), .DATA_W(32)) uut (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostKind(hostKind),
    .hostData(hostData), .hostReady(hostReady), .memReq(memReq), .memAck(memAck),
    .memAddr(memAddr), .memData(memData)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit expReadyF(bit v, logic [1:0] k);
    bit flushWait = v && (k != 2'b01) && (qA.size() != 0);
    return (qA.size() < DEPTH) && !flushWait;
  endfunction

  function automatic bit expReqF(bit v, logic [1:0] k);
    bit flushWait = v && (k != 2'b01) && (qA.size() != 0);
    return (qA.size() != 0) && (mBurst || qA.size() >= THRESH || flushWait);
  endfunction

  // One clock of stimulus: drive after a falling edge, check, then advance the reference.
  task automatic step(input bit v, input logic [1:0] k, input logic [31:0] d,
                      input bit a, input string tag, output bit acc);
    bit er, eq, pop, push;
    string rtag, qtag;
    hostValid = v; hostKind = k; hostData = d; memAck = a;
    #1;
    er = expReadyF(v, k);
    eq = expReqF(v, k);
    if (qA.size() == DEPTH)                  rtag = {tag, " R8"};
    else if (v && k != 2'b01 && qA.size() != 0) rtag = {tag, " R9"};
    else                                     rtag = {tag, " R7"};
    chk(hostReady == er, rtag, "hostReady", 32'(hostReady), 32'(er));
    if (!mBurst && qA.size() < THRESH && !(v && k != 2'b01 && qA.size() != 0))
      qtag = {tag, " R5"};
    else qtag = {tag, " R6"};
    chk(memReq == eq, qtag, "memReq", 32'(memReq), 32'(eq));
    if (eq) begin
      chk(memAddr == qA[0], {tag, " R3 R4"}, "memAddr", memAddr, qA[0]);
      chk(memData == qD[0], {tag, " R4"}, "memData", memData, qD[0]);
      if (prevHold) begin
        chk(memAddr == prevA && memData == prevD, {tag, " R11"}, "held addr",
            memAddr, prevA);
      end
    end
    prevHold = eq && !a;
    prevA = memAddr; prevD = memData;
    acc  = v && er;
    push = acc && (k == 2'b01);
    pop  = eq && a;
    @(posedge clk);
    if (pop) begin void'(qA.pop_front()); void'(qD.pop_front()); end
    if (push) begin qA.push_back(mAddr); qD.push_back(d); mAddr = mAddr + 1; end
    else if (acc && k == 2'b10) mAddr = d;
    mBurst = eq && (qA.size() != 0);
    @(negedge clk);
  endtask

  task automatic doReset(input string tag);
    bit dummy;
    @(negedge clk);
    rstN = 1'b0; hostValid = 1'b1; hostKind = 2'b01; memAck = 1'b0;
    #1;
    chk(hostReady == 1'b0, {tag, " R1"}, "hostReady in reset", 32'(hostReady), 0);
    chk(memReq == 1'b0, {tag, " R1"}, "memReq in reset", 32'(memReq), 0);
    qA.delete(); qD.delete(); mAddr = '0; mBurst = 0; prevHold = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step(1'b0, 2'b00, 32'h0, 1'b0, {tag, " R1"}, dummy);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit acc;
    bit pendV;
    logic [1:0] pendK;
    logic [31:0] pendD;
    void'($urandom(32'h5eed_a11f));
    doReset("R1");

    // R2 R3 R6: address load then five words with memory stalled
    step(1, 2'b10, 32'h0000_0100, 0, "R2", acc);
    for (int i = 0; i < 5; i++) step(1, 2'b01, 32'hA000_0000 + i, 0, "R3", acc);
    for (int i = 0; i < 6; i++) step(0, 2'b00, 0, 1, "R6", acc);

    // R5: three words below the threshold never raise a request
    step(1, 2'b10, 32'h0000_0200, 1, "R2", acc);
    for (int i = 0; i < 3; i++) step(1, 2'b01, 32'hB000_0000 + i, 1, "R5", acc);
    for (int i = 0; i < 2; i++) step(0, 2'b00, 0, 1, "R5", acc);

    // R9: address write waits for a forced drain
    for (int i = 0; i < 3; i++) step(1, 2'b10, 32'h0000_0300, 0, "R9", acc);
    acc = 0;
    for (int i = 0; i < 10 && !acc; i++) step(1, 2'b10, 32'h0000_0300, 1, "R9", acc);
    step(1, 2'b01, 32'hC000_0000, 0, "R2", acc);

    // R10: other access waits, then leaves pointer and queue alone
    acc = 0;
    for (int i = 0; i < 10 && !acc; i++) step(1, 2'b11, 32'hDEAD_BEEF, 1, "R10", acc);
    step(1, 2'b00, 32'h1234_5678, 1, "R10", acc);
    for (int i = 0; i < 4; i++) step(1, 2'b01, 32'hD000_0000 + i, 0, "R10", acc);
    for (int i = 0; i < 6; i++) step(0, 2'b00, 0, 1, "R10", acc);

    // R8: fill to full, then release one entry
    for (int i = 0; i < DEPTH + 2; i++) step(1, 2'b01, 32'hE000_0000 + i, 0, "R8", acc);
    step(1, 2'b01, 32'hE000_00FF, 1, "R8", acc);
    step(1, 2'b01, 32'hE000_00FF, 0, "R8", acc);
    for (int i = 0; i < DEPTH + 2; i++) step(0, 2'b00, 0, 1, "R8", acc);

    // R12: reset with entries queued
    for (int i = 0; i < 3; i++) step(1, 2'b01, 32'hF000_0000 + i, 0, "R12", acc);
    doReset("R12");
    for (int i = 0; i < THRESH; i++) step(1, 2'b01, 32'h0F00_0000 + i, 0, "R12", acc);
    chk(memAddr == 32'h0, "R12", "pointer after reset", memAddr, 32'h0);
    for (int i = 0; i < 6; i++) step(0, 2'b00, 0, 1, "R12", acc);

    // Random mix; a refused access is held until accepted
    pendV = 0; pendK = 0; pendD = 0;
    for (int i = 0; i < 3000; i++) begin
      int r;
      if (!pendV || acc) begin
        r = int'($urandom_range(0, 99));
        pendV = (r >= 10);
        if (r < 75)      pendK = 2'b01;
        else if (r < 85) pendK = 2'b10;
        else if (r < 92) pendK = 2'b00;
        else             pendK = 2'b11;
        pendD = $urandom;
      end
      step(pendV, pendK, pendD, ($urandom_range(0, 99) < 55), "R4", acc);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule